// File: doc/BRIEF.md
# CAN Identifier Acceptance Filter Bank

This block decides which receive buffer takes an incoming CAN identifier. It holds sixteen buffer slots by default. Each slot has a stored identifier, a frame-format flag (standard or extended) and a filter mode. A slot can compare every identifier bit, accept any identifier, or compare only the bits selected by one of two shared partial masks. The slot chooses which of the two masks it uses.

When the receive path presents an identifier, every slot is evaluated in parallel. The lowest-numbered slot that is enabled, not busy and matching wins. One clock later the block reports either a hit with the winner's index or a no-match.

Configuration is written through a simple address/data write port. The busy vector is driven by the buffer-management logic around the block, so a slot that still holds an unread message is skipped.

Top module: `can_accept_filter`

## Requirements
- R1: After reset, hit and no-match are low, the index is zero, every slot is disabled, and both partial masks are zero.
- R2: A write to address i (for i below the slot count) loads slot i. Data bits [28:0] are the identifier, bit 29 is the extended flag, and bits [31:30] are the mode: 0 compares all bits, 1 accepts all, 2 uses partial mask A, 3 uses partial mask B. Address 16 loads the enable vector (bit i enables slot i). Address 17 loads mask A from bits [28:0], and address 18 loads mask B from bits [28:0]. A write is in effect for a strobe in the next cycle.
- R3: In compare-all mode a slot matches only if every relevant identifier bit equals its stored identifier.
- R4: In accept-all mode a slot matches any identifier of its frame format.
- R5: In partial-mask mode only the bit positions set in the selected shared mask (A or B) are compared, and the other bits are don't-care.
- R6: A slot never matches a frame whose extended flag differs from the slot's stored flag.
- R7: A standard identifier is carried in identifier bits [28:18]. For standard frames, bits [17:0] of the incoming identifier, the stored identifier and the masks are ignored.
- R8: When several slots qualify, the lowest-numbered one is reported.
- R9: A disabled slot, or a slot whose busy bit is high in the strobe cycle, is never reported.
- R10: In the cycle after a strobe, exactly one of hit and no-match is high, and with a hit the index names the winner. In the cycle after a cycle without a strobe, both are low and the index keeps its last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cfg_we_i | input | 1 | Configuration write enable |
| cfg_addr_i | input | ADDR_W (5) | Configuration address |
| cfg_wdata_i | input | 32 | Configuration write data |
| rx_valid_i | input | 1 | Identifier-valid strobe |
| rx_id_i | input | 29 | Received identifier (standard in bits 28:18) |
| rx_ide_i | input | 1 | Received frame is extended |
| buf_busy_i | input | NUM_BUF (16) | Per-slot busy |
| hit_o | output | 1 | A slot accepted the identifier |
| buf_idx_o | output | IDX_W (4) | Index of the accepting slot |
| nomatch_o | output | 1 | No slot accepted the identifier |

## Verification
The hardest situation to reach is priority resolution among several slots that qualify at once through different partial masks. The case where the lower winner is then removed by busy or enable gating is equally hard. The stimulus sets up mask A and mask B slots whose stored identifiers differ, then picks an identifier built to satisfy both masks. That identifier is sent three times: plain, with the lower slot marked busy, and with both slots disabled. The reported index moves from one slot to the other and then to no-match.

// File: rtl/caf_pkg.sv
package caf_pkg;
  localparam int ID_W  = 29;
  localparam int STD_W = 11;

  typedef enum logic [1:0] {
    FM_EXACT  = 2'd0,
    FM_ALL    = 2'd1,
    FM_PART_A = 2'd2,
    FM_PART_B = 2'd3
  } fmode_e;

  // Layout equals the 32-bit configuration word of a slot.
  typedef struct packed {
    fmode_e          mode;
    logic            ide;
    logic [ID_W-1:0] id;
  } bufcfg_t;
endpackage

// File: rtl/caf_cfg_regs.sv
module caf_cfg_regs
  import caf_pkg::*;
#(
  parameter int NUM_BUF = 16,
  parameter int ADDR_W  = 5
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      cfg_we_i,
  input  logic [ADDR_W-1:0]         cfg_addr_i,
  input  logic [31:0]               cfg_wdata_i,
  output bufcfg_t [NUM_BUF-1:0]     buf_cfg_o,
  output logic [NUM_BUF-1:0]        buf_en_o,
  output logic [ID_W-1:0]           mask_a_o,
  output logic [ID_W-1:0]           mask_b_o
);
  localparam int EN_ADDR = NUM_BUF;
  localparam int MA_ADDR = NUM_BUF + 1;
  localparam int MB_ADDR = NUM_BUF + 2;

  for (genvar g = 0; g < NUM_BUF; g++) begin : g_slot
    logic    wr_en;
    bufcfg_t cfg_d;
    bufcfg_t cfg_q;

    assign wr_en = cfg_we_i && (cfg_addr_i == ADDR_W'(g));

    always_comb begin
      cfg_d = bufcfg_t'(cfg_wdata_i);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)    cfg_q <= '0;
      else if (wr_en) cfg_q <= cfg_d;
    end

    assign buf_cfg_o[g] = cfg_q;
  end

  logic                en_we, ma_we, mb_we;
  logic [NUM_BUF-1:0]  en_d, en_q;
  logic [ID_W-1:0]     ma_d, ma_q, mb_d, mb_q;

  always_comb begin
    en_we = cfg_we_i && (cfg_addr_i == ADDR_W'(EN_ADDR));
    ma_we = cfg_we_i && (cfg_addr_i == ADDR_W'(MA_ADDR));
    mb_we = cfg_we_i && (cfg_addr_i == ADDR_W'(MB_ADDR));
    en_d  = cfg_wdata_i[NUM_BUF-1:0];
    ma_d  = cfg_wdata_i[ID_W-1:0];
    mb_d  = cfg_wdata_i[ID_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    en_q <= '0;
    else if (en_we) en_q <= en_d;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    ma_q <= '0;
    else if (ma_we) ma_q <= ma_d;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    mb_q <= '0;
    else if (mb_we) mb_q <= mb_d;
  end

  assign buf_en_o = en_q;
  assign mask_a_o = ma_q;
  assign mask_b_o = mb_q;
endmodule

// File: rtl/caf_buf_match.sv
module caf_buf_match
  import caf_pkg::*;
(
  input  bufcfg_t         cfg_i,
  input  logic            en_i,
  input  logic            busy_i,
  input  logic [ID_W-1:0] rx_id_i,
  input  logic            rx_ide_i,
  input  logic [ID_W-1:0] mask_a_i,
  input  logic [ID_W-1:0] mask_b_i,
  output logic            match_o
);
  localparam logic [ID_W-1:0] STD_CARE = {{STD_W{1'b1}}, {(ID_W-STD_W){1'b0}}};

  logic [ID_W-1:0] mode_care;
  logic [ID_W-1:0] frame_care;
  logic            id_ok;

  always_comb begin
    unique case (cfg_i.mode)
      FM_EXACT:  mode_care = '1;
      FM_ALL:    mode_care = '0;
      FM_PART_A: mode_care = mask_a_i;
      FM_PART_B: mode_care = mask_b_i;
      default:   mode_care = '1;
    endcase
    frame_care = rx_ide_i ? '1 : STD_CARE;
    id_ok      = ~|((rx_id_i ^ cfg_i.id) & mode_care & frame_care);
    match_o    = en_i && !busy_i && (cfg_i.ide == rx_ide_i) && id_ok;
  end
endmodule

// File: rtl/caf_prio_enc.sv
module caf_prio_enc #(
  parameter int N     = 16,
  parameter int IDX_W = 4
) (
  input  logic [N-1:0]     req_i,
  output logic             any_o,
  output logic [IDX_W-1:0] idx_o
);
  always_comb begin
    any_o = |req_i;
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = IDX_W'(i);
    end
  end
endmodule

// File: rtl/can_accept_filter.sv
module can_accept_filter
  import caf_pkg::*;
#(
  parameter  int NUM_BUF = 16,
  localparam int IDX_W   = (NUM_BUF > 1) ? $clog2(NUM_BUF) : 1,
  localparam int ADDR_W  = $clog2(NUM_BUF + 3)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                cfg_we_i,
  input  logic [ADDR_W-1:0]   cfg_addr_i,
  input  logic [31:0]         cfg_wdata_i,
  input  logic                rx_valid_i,
  input  logic [ID_W-1:0]     rx_id_i,
  input  logic                rx_ide_i,
  input  logic [NUM_BUF-1:0]  buf_busy_i,
  output logic                hit_o,
  output logic [IDX_W-1:0]    buf_idx_o,
  output logic                nomatch_o
);
  bufcfg_t [NUM_BUF-1:0] buf_cfg;
  logic    [NUM_BUF-1:0] buf_en;
  logic    [ID_W-1:0]    mask_a, mask_b;
  logic    [NUM_BUF-1:0] match_vec;
  logic                  any_match;
  logic    [IDX_W-1:0]   win_idx;

  caf_cfg_regs #(.NUM_BUF(NUM_BUF), .ADDR_W(ADDR_W)) u_cfg (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cfg_we_i    (cfg_we_i),
    .cfg_addr_i  (cfg_addr_i),
    .cfg_wdata_i (cfg_wdata_i),
    .buf_cfg_o   (buf_cfg),
    .buf_en_o    (buf_en),
    .mask_a_o    (mask_a),
    .mask_b_o    (mask_b)
  );

  for (genvar g = 0; g < NUM_BUF; g++) begin : g_match
    caf_buf_match u_match (
      .cfg_i    (buf_cfg[g]),
      .en_i     (buf_en[g]),
      .busy_i   (buf_busy_i[g]),
      .rx_id_i  (rx_id_i),
      .rx_ide_i (rx_ide_i),
      .mask_a_i (mask_a),
      .mask_b_i (mask_b),
      .match_o  (match_vec[g])
    );
  end

  caf_prio_enc #(.N(NUM_BUF), .IDX_W(IDX_W)) u_prio (
    .req_i (match_vec),
    .any_o (any_match),
    .idx_o (win_idx)
  );

  logic             hit_d, hit_q, nm_d, nm_q;
  logic [IDX_W-1:0] idx_d, idx_q;

  always_comb begin
    hit_d = rx_valid_i && any_match;
    nm_d  = rx_valid_i && !any_match;
    idx_d = hit_d ? win_idx : idx_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hit_q <= 1'b0;
      nm_q  <= 1'b0;
      idx_q <= '0;
    end else begin
      hit_q <= hit_d;
      nm_q  <= nm_d;
      idx_q <= idx_d;
    end
  end

  assign hit_o     = hit_q;
  assign nomatch_o = nm_q;
  assign buf_idx_o = idx_q;
endmodule

// File: rtl/caf_checker.sv
module caf_checker #(
  parameter int NUM_BUF = 16,
  parameter int IDX_W   = 4
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               rx_valid_i,
  input logic [NUM_BUF-1:0] buf_busy_i,
  input logic [NUM_BUF-1:0] buf_en_i,
  input logic               hit_o,
  input logic [IDX_W-1:0]   buf_idx_o,
  input logic               nomatch_o
);
  logic [NUM_BUF-1:0] busy_q, en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= '0;
      en_q   <= '0;
    end else begin
      busy_q <= buf_busy_i;
      en_q   <= buf_en_i;
    end
  end

  // R10
  one_result_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_i |=> ($countones({hit_o, nomatch_o}) == 1));

  // R10
  no_spurious_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rx_valid_i |=> (!hit_o && !nomatch_o));

  // R10
  idx_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hit_o |-> $stable(buf_idx_o));

  // R9
  winner_free_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> (en_q[buf_idx_o] && !busy_q[buf_idx_o]));
endmodule

bind can_accept_filter caf_checker #(.NUM_BUF(NUM_BUF), .IDX_W(IDX_W)) u_caf_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .rx_valid_i (rx_valid_i),
  .buf_busy_i (buf_busy_i),
  .buf_en_i   (buf_en),
  .hit_o      (hit_o),
  .buf_idx_o  (buf_idx_o),
  .nomatch_o  (nomatch_o)
);

// File: tb/can_accept_filter_bench.sv
module can_accept_filter_bench;
  localparam int NB = 16;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we;
  logic [4:0]  cfg_addr;
  logic [31:0] cfg_wdata;
  logic        rx_valid;
  logic [28:0] rx_id;
  logic        rx_ide;
  logic [NB-1:0] busy;
  logic        hit, nomatch;
  logic [3:0]  idx;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  always #2 clk = ~clk;

  can_accept_filter #(.NUM_BUF(NB)) u_can_accept_filter (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(cfg_we), .cfg_addr_i(cfg_addr),
    .cfg_wdata_i(cfg_wdata), .rx_valid_i(rx_valid), .rx_id_i(rx_id),
    .rx_ide_i(rx_ide), .buf_busy_i(busy), .hit_o(hit), .buf_idx_o(idx),
    .nomatch_o(nomatch)
  );

  localparam logic [28:0] X_ID = 29'h1ABCDEF0;
  localparam logic [28:0] Y_ID = 29'h12345678;
  localparam logic [28:0] Z_ID = 29'h00000AB5;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(int addr, logic [31:0] data);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 5'(addr); cfg_wdata = data;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  function automatic logic [31:0] slot(logic [1:0] mode, logic ide, logic [28:0] id);
    return {mode, ide, id};
  endfunction

  // drives one strobe and checks the registered result
  task automatic send(string req, logic [28:0] id, logic ide, bit exp_hit, int exp_idx);
    @(negedge clk);
    rx_valid = 1'b1; rx_id = id; rx_ide = ide;
    @(negedge clk);
    rx_valid = 1'b0;
    chk(req, {31'd0, hit}, {31'd0, exp_hit});
    chk(req, {31'd0, nomatch}, {31'd0, !exp_hit});
    if (exp_hit) chk(req, {28'd0, idx}, 32'(exp_idx));
  endtask

  task automatic t_reset();
    chk("R1 hit", {31'd0, hit}, 0);
    chk("R1 nomatch", {31'd0, nomatch}, 0);
    chk("R1 idx", {28'd0, idx}, 0);
    // R1: nothing enabled, so any strobe misses
    send("R1 disabled", 29'd0, 1'b0, 0, 0);
  endtask

  task automatic t_setup();
    // R2 map: slots 0..15, enables at 16, mask A 17, mask B 18
    wr(0, slot(2'd0, 1'b0, 29'h048EAAAA));
    wr(1, slot(2'd2, 1'b1, Y_ID));
    wr(2, slot(2'd3, 1'b1, Z_ID));
    wr(3, slot(2'd0, 1'b1, X_ID));
    wr(5, slot(2'd1, 1'b0, 29'd0));
    wr(17, 32'h1FE00000);
    wr(18, 32'h0000000F);
    wr(16, 32'h0000002F);
  endtask

  task automatic t_exact();
    send("R3 R2 exact hit", X_ID, 1'b1, 1, 3);
    send("R3 exact miss", X_ID ^ 29'd1, 1'b1, 0, 0);
  endtask

  task automatic t_ide();
    // R6: slot 3 rejected on format, accept-all slot 5 takes it (R4)
    send("R6 R4 ide", X_ID, 1'b0, 1, 5);
  endtask

  task automatic t_masks();
    send("R5 mask A hit", 29'h1234FFFF, 1'b1, 1, 1);
    send("R5 mask A miss", 29'h0234FFFF, 1'b1, 0, 0);
    send("R5 mask B hit", 29'h0ABCDEF5, 1'b1, 1, 2);
  endtask

  task automatic t_prio_gate();
    send("R8 priority", 29'h12200005, 1'b1, 1, 1);
    busy = 16'h0002;
    send("R9 busy", 29'h12200005, 1'b1, 1, 2);
    busy = '0;
    wr(16, 32'h00000029);
    send("R9 disabled", 29'h12200005, 1'b1, 0, 0);
    wr(16, 32'h0000002F);
  endtask

  task automatic t_std();
    send("R7 std low bits ignored", 29'h048D5555, 1'b0, 1, 0);
    send("R7 std miss", 29'h04900000, 1'b0, 1, 5);
  endtask

  task automatic t_idle();
    @(negedge clk);
    chk("R10 idle hit", {31'd0, hit}, 0);
    chk("R10 idle nomatch", {31'd0, nomatch}, 0);
    chk("R10 idx hold", {28'd0, idx}, 5);
  endtask

  task automatic t_last();
    wr(15, slot(2'd1, 1'b1, 29'd0));
    wr(16, 32'h00008000);
    send("R8 last slot", X_ID, 1'b1, 1, 15);
    send("R6 last slot format", X_ID, 1'b0, 0, 0);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=running expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
    rx_valid = 1'b0; rx_id = '0; rx_ide = 1'b0; busy = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_setup();
    t_exact();
    t_ide();
    t_masks();
    t_prio_gate();
    t_std();
    t_idle();
    t_last();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule